// File: doc/BRIEF.md
# Dual-Regulator Domain Switch Sequencer

This block sequences the power switches that join two logic domains of a chip that has two regulators on one supply. The reduced domain holds everything needed to boot and debug: clocks and resets, the processor, debug, RAM, flash and basic safety logic. It is fed by a fast auxiliary regulator. The extended domain holds the rest and is fed by the slower main regulator. A cross-domain switch ties the two together, and isolation clamps guard every signal that crosses between them.

After a start pulse, the sequencer lets the reduced domain leave reset as soon as the auxiliary rail is good. This happens without waiting for the main rail, which shortens boot. It watches both power-on-reset indications against a programmable timeout. A partial power failure does not hold the whole chip in reset. Instead the sequencer degrades to whichever rail survived and records the failure in sticky status bits. It picks the boot address that matches what is still powered. If the main rail comes back after it was lost, the sequencer waits for a debounce interval and then re-joins the domains.

Software reads the status through a small read port and clears each bit by writing a one to it.

Top module: `dual_rail_seq`

## Requirements
- R1: After reset, every switch enable is low, `iso_en` is high, both domain resets are held (`rdom_rst_n`=0, `edom_rst_n`=0), `boot_sel` is 0 and `reg_rdata` is 0.
- R2: While waiting after `seq_go`, `sw_aux_en` rises one cycle after `aux_por_ok` and `aux_rdy` are both high. `rdom_rst_n` rises one cycle after that. Both happen while the main rail is still off and `edom_rst_n` stays 0.
- R3: When both rail switches are closed, `sw_xdom_en` closes on the next cycle. On the cycle after that, `iso_en` falls and `edom_rst_n` rises.
- R4: If only the auxiliary switch has closed when the wait counter reaches `tmo_limit`, status bit 1 (main failure) is set. The main and cross-domain switches stay open and the reduced domain keeps running.
- R5: If only the main switch has closed at the timeout, status bit 0 (auxiliary failure) is set. `sw_aux_en` stays open, the cross-domain switch closes, and both domains are released, so the main rail runs the chip.
- R6: If neither switch has closed at the timeout, status bit 2 (dual failure) is set. From then until reset, every switch stays open and both domain resets stay held, even if the rails later come up.
- R7: `iso_en` is high whenever `sw_xdom_en` is low. It is high for at least one cycle before `sw_xdom_en` opens, and it falls only one cycle after `sw_xdom_en` has closed.
- R8: If `main_por_ok` falls while running with both domains, `iso_en` rises and `edom_rst_n` falls on the next cycle. On the cycle after that, the main and cross-domain switches open and status bit 1 is set.
- R9: In reduced-only operation, the main rail must be good (`main_por_ok` and `main_rdy`) for `dbn_len` consecutive cycles. A single bad cycle restarts the count. The main switch then closes, then the cross-domain switch, then the clamps release. Status bit 3 (reconfiguration done) is set on that last step.
- R10: Status bits are sticky. A `reg_wr` with a 1 in a bit of `reg_wdata` clears that bit one cycle later. Zeros in `reg_wdata` leave their bits unchanged. A failure event in the same cycle as a clear wins.
- R11: `boot_sel` is 1 (reduced-only start address) exactly while the chip runs from the reduced domain alone after a main failure. It is 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_go | input | 1 | Pulse that starts the power-up sequence |
| aux_por_ok | input | 1 | Auxiliary-side low-voltage POR has lifted |
| main_por_ok | input | 1 | Main-side low-voltage POR has lifted |
| aux_rdy | input | 1 | Auxiliary regulator reports ready |
| main_rdy | input | 1 | Main regulator reports ready |
| tmo_limit | input | TMO_W | Cycles to wait for the POR flags before declaring failure |
| dbn_len | input | DBN_W | Consecutive good cycles required before re-joining after main recovery |
| reg_wr | input | 1 | Status write strobe (write-one-to-clear) |
| reg_wdata | input | 4 | Status clear mask |
| reg_rdata | output | 4 | Status: bit0 aux fail, bit1 main fail, bit2 dual fail, bit3 reconfiguration done |
| sw_aux_en | output | 1 | Close the auxiliary rail switch |
| sw_main_en | output | 1 | Close the main rail switch |
| sw_xdom_en | output | 1 | Close the cross-domain switch |
| iso_en | output | 1 | Clamp the signals that cross between domains |
| boot_sel | output | 1 | 1 selects the reduced-only boot address |
| rdom_rst_n | output | 1 | Reduced-domain reset release |
| edom_rst_n | output | 1 | Extended-domain reset release |

## Verification
The sequence is driven with four rail patterns: both rails good, only the auxiliary rail, only the main rail, and neither. These separate the four ways the timeout can resolve and confirm that each sets only its own status bit. A run that loses the main rail and then regains it checks the ordering of clamp and switch in both directions. A one-cycle glitch during the debounce checks that the count restarts rather than accumulates. Status writes mixing ones and zeros separate clearing from leaving a bit alone.

// File: rtl/drs_pkg.sv
package drs_pkg;

    localparam int unsigned STAT_N   = 4;
    localparam int unsigned ST_AUXF  = 0;
    localparam int unsigned ST_MAINF = 1;
    localparam int unsigned ST_DUALF = 2;
    localparam int unsigned ST_RECFG = 3;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_LINK,
        SQ_RUN,
        SQ_ISO,
        SQ_RED,
        SQ_RMAIN,
        SQ_DEAD
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       sw_aux;
        logic       sw_main;
        logic       sw_xdom;
        logic       iso;
        logic       boot_red;
        logic       rdom_rel;
        logic       edom_rel;
        logic       rec;
    } seq_ctl_t;

endpackage

// File: rtl/por_timer.sv
module por_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && (cnt_q != limit)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = en && (cnt_q == limit);
endmodule

// File: rtl/rail_debounce.sv
module rail_debounce #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         good,
    input  logic [W-1:0] len,
    output logic         stable
);
    logic [W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!en || !good) begin
            run_d = '0;
        end else if (run_q != len) begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign stable = en && good && (run_q == len);
endmodule

// File: rtl/stat_bank.sv
module stat_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         wr,
    input  logic [N-1:0] wmask,
    output logic [N-1:0] q
);
    logic [N-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        for (int i = 0; i < int'(N); i++) begin
            if (wr && wmask[i]) bits_d[i] = 1'b0;
            if (set[i])         bits_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign q = bits_q;
endmodule

// File: rtl/dual_rail_seq.sv
module dual_rail_seq
    import drs_pkg::*;
#(
    parameter int unsigned TMO_W = 16,
    parameter int unsigned DBN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_go,
    input  logic              aux_por_ok,
    input  logic              main_por_ok,
    input  logic              aux_rdy,
    input  logic              main_rdy,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic [DBN_W-1:0]  dbn_len,
    input  logic              reg_wr,
    input  logic [STAT_N-1:0] reg_wdata,
    output logic [STAT_N-1:0] reg_rdata,
    output logic              sw_aux_en,
    output logic              sw_main_en,
    output logic              sw_xdom_en,
    output logic              iso_en,
    output logic              boot_sel,
    output logic              rdom_rst_n,
    output logic              edom_rst_n
);
    localparam seq_ctl_t CTL_RESET = '{
        st:       SQ_IDLE,
        sw_aux:   1'b0,
        sw_main:  1'b0,
        sw_xdom:  1'b0,
        iso:      1'b1,
        boot_red: 1'b0,
        rdom_rel: 1'b0,
        edom_rel: 1'b0,
        rec:      1'b0
    };

    seq_ctl_t          ctl_d, ctl_q;
    seq_state_e        nst;
    logic [STAT_N-1:0] stat_set;
    logic              aux_good, main_good;
    logic              tmo_hit, main_steady;

    assign aux_good  = aux_por_ok  && aux_rdy;
    assign main_good = main_por_ok && main_rdy;

    por_timer #(.W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctl_q.st != SQ_WAIT),
        .en      (ctl_q.st == SQ_WAIT),
        .limit   (tmo_limit),
        .expired (tmo_hit)
    );

    rail_debounce #(.W(DBN_W)) u_dbn (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl_q.st == SQ_RED),
        .good   (main_good),
        .len    (dbn_len),
        .stable (main_steady)
    );

    stat_bank #(.N(STAT_N)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stat_set),
        .wr    (reg_wr),
        .wmask (reg_wdata),
        .q     (reg_rdata)
    );

    // next state and failure events
    always_comb begin
        nst      = ctl_q.st;
        stat_set = '0;
        unique case (ctl_q.st)
            SQ_IDLE: if (seq_go) nst = SQ_WAIT;
            SQ_WAIT: begin
                if (ctl_q.sw_aux && ctl_q.sw_main) begin
                    nst = SQ_LINK;
                end else if (tmo_hit) begin
                    if (ctl_q.sw_aux) begin
                        nst = SQ_RED;
                        stat_set[ST_MAINF] = 1'b1;
                    end else if (ctl_q.sw_main) begin
                        nst = SQ_LINK;
                        stat_set[ST_AUXF] = 1'b1;
                    end else begin
                        nst = SQ_DEAD;
                        stat_set[ST_DUALF] = 1'b1;
                    end
                end
            end
            SQ_LINK: begin
                nst = SQ_RUN;
                if (ctl_q.rec) stat_set[ST_RECFG] = 1'b1;
            end
            SQ_RUN:  if (!main_por_ok) nst = SQ_ISO;
            SQ_ISO: begin
                if (ctl_q.sw_aux) begin
                    nst = SQ_RED;
                    stat_set[ST_MAINF] = 1'b1;
                end else begin
                    nst = SQ_DEAD;
                    stat_set[ST_DUALF] = 1'b1;
                end
            end
            SQ_RED:   if (main_steady) nst = SQ_RMAIN;
            SQ_RMAIN: nst = main_good ? SQ_LINK : SQ_RED;
            SQ_DEAD:  nst = SQ_DEAD;
            default:  nst = SQ_IDLE;
        endcase
    end

    // registered outputs, chosen by the state being entered
    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.st = nst;
        unique case (nst)
            SQ_IDLE: ctl_d = CTL_RESET;
            SQ_WAIT: begin
                ctl_d.sw_aux   = aux_good;
                ctl_d.sw_main  = main_good;
                ctl_d.sw_xdom  = 1'b0;
                ctl_d.iso      = 1'b1;
                ctl_d.boot_red = 1'b0;
                ctl_d.rdom_rel = ctl_q.sw_aux && aux_good;
                ctl_d.edom_rel = 1'b0;
            end
            SQ_LINK: begin
                ctl_d.sw_xdom  = 1'b1;
                ctl_d.iso      = 1'b1;
                ctl_d.boot_red = 1'b0;
            end
            SQ_RUN: begin
                ctl_d.iso      = 1'b0;
                ctl_d.boot_red = 1'b0;
                ctl_d.rdom_rel = 1'b1;
                ctl_d.edom_rel = 1'b1;
                ctl_d.rec      = 1'b0;
            end
            SQ_ISO: begin
                ctl_d.iso      = 1'b1;
                ctl_d.edom_rel = 1'b0;
            end
            SQ_RED: begin
                ctl_d.sw_main  = 1'b0;
                ctl_d.sw_xdom  = 1'b0;
                ctl_d.iso      = 1'b1;
                ctl_d.boot_red = 1'b1;
                ctl_d.rdom_rel = 1'b1;
                ctl_d.edom_rel = 1'b0;
            end
            SQ_RMAIN: begin
                ctl_d.sw_main  = 1'b1;
                ctl_d.sw_xdom  = 1'b0;
                ctl_d.iso      = 1'b1;
                ctl_d.boot_red = 1'b1;
                ctl_d.rec      = 1'b1;
            end
            SQ_DEAD: begin
                ctl_d          = CTL_RESET;
                ctl_d.st       = SQ_DEAD;
            end
            default: ctl_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign sw_aux_en  = ctl_q.sw_aux;
    assign sw_main_en = ctl_q.sw_main;
    assign sw_xdom_en = ctl_q.sw_xdom;
    assign iso_en     = ctl_q.iso;
    assign boot_sel   = ctl_q.boot_red;
    assign rdom_rst_n = ctl_q.rdom_rel;
    assign edom_rst_n = ctl_q.edom_rel;
endmodule

// File: rtl/dual_rail_seq_chk.sv
module dual_rail_seq_chk
    import drs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [STAT_N-1:0] reg_wdata,
    input logic [STAT_N-1:0] reg_rdata,
    input logic              sw_aux_en,
    input logic              sw_main_en,
    input logic              sw_xdom_en,
    input logic              iso_en,
    input logic              boot_sel,
    input logic              rdom_rst_n,
    input logic              edom_rst_n
);
    p_rdom_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdom_rst_n |-> (sw_aux_en || sw_xdom_en));

    p_xdom_needs_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_xdom_en |-> sw_main_en);

    p_clamp_when_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_xdom_en |-> iso_en);

    p_clamp_before_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_xdom_en) |-> $past(iso_en));

    p_release_after_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> $past(sw_xdom_en));

    p_dual_all_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[ST_DUALF] |-> (!sw_aux_en && !sw_main_en && !sw_xdom_en && !rdom_rst_n && !edom_rst_n));

    p_reduced_boot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        boot_sel |-> (!sw_xdom_en && !edom_rst_n && rdom_rst_n));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(reg_rdata) & ~reg_rdata & ~($past(reg_wdata) & {STAT_N{$past(reg_wr)}})) == '0));
endmodule

bind dual_rail_seq dual_rail_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .sw_aux_en  (sw_aux_en),
    .sw_main_en (sw_main_en),
    .sw_xdom_en (sw_xdom_en),
    .iso_en     (iso_en),
    .boot_sel   (boot_sel),
    .rdom_rst_n (rdom_rst_n),
    .edom_rst_n (edom_rst_n)
);

// File: tb/test_dual_rail_seq.sv
module test_dual_rail_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seq_go = 1'b0;
    logic        aux_por_ok = 1'b0, main_por_ok = 1'b0, aux_rdy = 1'b0, main_rdy = 1'b0;
    logic [15:0] tmo_limit = 16'd20;
    logic [15:0] dbn_len = 16'd10;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_wdata = 4'h0;
    logic [3:0]  reg_rdata;
    logic        sw_aux_en, sw_main_en, sw_xdom_en, iso_en, boot_sel, rdom_rst_n, edom_rst_n;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_rail_seq i_dual_rail_seq (
        .clk(clk), .rst_n(rst_n), .seq_go(seq_go),
        .aux_por_ok(aux_por_ok), .main_por_ok(main_por_ok),
        .aux_rdy(aux_rdy), .main_rdy(main_rdy),
        .tmo_limit(tmo_limit), .dbn_len(dbn_len),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sw_aux_en(sw_aux_en), .sw_main_en(sw_main_en), .sw_xdom_en(sw_xdom_en),
        .iso_en(iso_en), .boot_sel(boot_sel),
        .rdom_rst_n(rdom_rst_n), .edom_rst_n(edom_rst_n)
    );

    // packed view of outputs: {aux, main, xdom, iso, boot, rdom, edom}
    function automatic logic [6:0] outs();
        return {sw_aux_en, sw_main_en, sw_xdom_en, iso_en, boot_sel, rdom_rst_n, edom_rst_n};
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; seq_go = 1'b0; reg_wr = 1'b0; reg_wdata = 4'h0;
        aux_por_ok = 1'b0; main_por_ok = 1'b0; aux_rdy = 1'b0; main_rdy = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic go();
        seq_go = 1'b1;
        step(1);
        seq_go = 1'b0;
    endtask

    task automatic wait_stat(input int lim);
        for (int i = 0; i < lim; i++) begin
            if (reg_rdata != 4'h0) break;
            step(1);
        end
    endtask

    // R1, R2, R3, R8, R9, R7, R11
    task automatic t_full_then_loss();
        do_reset();
        chk("R1 reset outputs", outs(), 7'b0001000);
        chk("R1 reset status", reg_rdata, 4'h0);
        tmo_limit = 16'd40; dbn_len = 16'd10;
        go();
        aux_por_ok = 1'b1; aux_rdy = 1'b1;
        step(1);
        chk("R2 aux switch closes", sw_aux_en, 1'b1);
        chk("R2 reduced still held", rdom_rst_n, 1'b0);
        step(1);
        chk("R2 early boot outputs", outs(), 7'b1001010);
        step(4);
        main_rdy = 1'b1; main_por_ok = 1'b1;
        step(1);
        chk("R3 main switch", outs(), 7'b1101010);
        step(1);
        chk("R3 cross switch, clamp held", outs(), 7'b1111010);
        step(1);
        chk("R3 R7 clamp release", outs(), 7'b1110011);
        chk("R3 no failure", reg_rdata, 4'h0);
        main_por_ok = 1'b0;
        step(1);
        chk("R8 R7 clamp first", outs(), 7'b1111010);
        step(1);
        chk("R8 R11 reduced only", outs(), 7'b1001110);
        chk("R8 main fail bit", reg_rdata, 4'h2);
        // recovery with a glitch
        main_por_ok = 1'b1;
        step(5);
        main_por_ok = 1'b0;
        step(1);
        main_por_ok = 1'b1;
        step(10);
        chk("R9 glitch restarts debounce", sw_main_en, 1'b0);
        step(1);
        chk("R9 main closes first", outs(), 7'b1101110);
        step(1);
        chk("R9 cross closes", outs(), 7'b1111010);
        step(1);
        chk("R9 R11 rejoined", outs(), 7'b1110011);
        chk("R9 reconfig bit", reg_rdata, 4'hA);
    endtask

    // R10
    task automatic t_w1c();
        step(3);
        chk("R10 sticky hold", reg_rdata, 4'hA);
        reg_wr = 1'b1; reg_wdata = 4'h2;
        step(1);
        reg_wr = 1'b0;
        chk("R10 clear one bit", reg_rdata, 4'h8);
        reg_wr = 1'b1; reg_wdata = 4'h0;
        step(1);
        reg_wr = 1'b0;
        chk("R10 zero write no effect", reg_rdata, 4'h8);
        reg_wr = 1'b1; reg_wdata = 4'h8;
        step(1);
        reg_wr = 1'b0;
        chk("R10 clear last bit", reg_rdata, 4'h0);
    endtask

    // R4, R11
    task automatic t_main_absent();
        do_reset();
        tmo_limit = 16'd20;
        go();
        aux_por_ok = 1'b1; aux_rdy = 1'b1;
        step(12);
        chk("R4 no flag before timeout", reg_rdata, 4'h0);
        wait_stat(30);
        chk("R4 main fail bit", reg_rdata, 4'h2);
        chk("R4 R11 reduced only", outs(), 7'b1001110);
    endtask

    // R5
    task automatic t_aux_absent();
        do_reset();
        tmo_limit = 16'd20;
        go();
        main_por_ok = 1'b1; main_rdy = 1'b1;
        step(12);
        chk("R5 no flag before timeout", reg_rdata, 4'h0);
        wait_stat(30);
        chk("R5 aux fail bit", reg_rdata, 4'h1);
        step(1);
        chk("R5 main runs chip", outs(), 7'b0110011);
    endtask

    // R6
    task automatic t_dual();
        do_reset();
        tmo_limit = 16'd20;
        go();
        wait_stat(40);
        chk("R6 dual fail bit", reg_rdata, 4'h4);
        chk("R6 all open", outs(), 7'b0001000);
        aux_por_ok = 1'b1; aux_rdy = 1'b1; main_por_ok = 1'b1; main_rdy = 1'b1;
        step(10);
        chk("R6 stays open after rails rise", outs(), 7'b0001000);
        chk("R6 status sticky", reg_rdata, 4'h4);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_full_then_loss();
        t_w1c();
        t_main_absent();
        t_aux_absent();
        t_dual();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule